// File: doc/BRIEF.md
# UART Receive Buffer with Line Status

This block is the receive-side holding store of a memory-mapped serial port. A deserializer upstream hands it 12-bit entries. Each entry has eight data bits in bits 7:0 and four error bits in bits 11:8. Bit 10 of an entry marks a line break. The block keeps the entries in a circular store of 16 slots. It hands the oldest entry back on each read strobe of the data register.

The block drives three outputs that software reads through the register file:

- an 8-bit flag image,
- a 4-bit latched error status,
- a receive interrupt level.

It also gives the source a combinational accept signal, so that the source can hold off a push that would otherwise be lost.

The FIFO-enable bit selects the mode. With the bit set, the store holds up to 16 entries. With the bit clear, it acts as a single holding register.

The occupancy is tracked by a three-state machine:

- `OCC_EMPTY` holds no entry.
- `OCC_PARTIAL` holds some entries but is below the mode's capacity.
- `OCC_FULL` is at the capacity: 16 entries in FIFO mode, 1 entry in single mode.

Each cycle the next state is picked from the next entry count and the mode:

- A push moves `OCC_EMPTY` to `OCC_PARTIAL`, or to `OCC_FULL` when the capacity is reached.
- A pop moves `OCC_FULL` to `OCC_PARTIAL`, or to `OCC_EMPTY`, and moves `OCC_PARTIAL` to `OCC_EMPTY`.
- A change of the mode bit is the flush transition. From any state it returns to `OCC_EMPTY`.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, `flags` reads 0x90 (bit 7 transmit-empty always 1, bit 4 receive-empty 1, bit 6 receive-full 0, all other bits 0). `rx_status` is 0, `rx_irq` is 0, `can_accept` is 1 and `rd_data` is 0. The FIFO-enable mode is taken as 0 at reset.
- R2: With `fifo_en`=1, up to 16 entries are held. `flags` bit 6 is 1 exactly when 16 entries are held, and `can_accept` is then 0.
- R3: With `fifo_en`=0, one entry is held. `flags` bit 6 is 1 while it is held, and `can_accept` is 0 then.
- R4: A push (or break) offered while `can_accept` is 0 is discarded. The count and the stored entries stay unchanged.
- R5: `rd_data` always shows the entry at the read pointer. A read strobe with at least one entry held pops it. Entries come out in push order, and the pointers wrap from slot 15 to slot 0.
- R6: A read strobe with no entry held pops nothing. The count stays 0, and `rd_data` keeps showing the stale entry at the unchanged pointer.
- R7: `flags` bit 4 is 1 exactly when no entry is held.
- R8: On each read strobe, bits 11:8 of `rd_data` are copied into `rx_status` at the clock edge. A `stat_wr` strobe clears `rx_status` to 0, and the clear wins over a read in the same cycle.
- R9: `rx_irq` is set when a push alone raises the count to 1, and cleared when a pop alone lowers the count to 0. A flush leaves it unchanged.
- R10: A `break_evt` strobe pushes the entry 0x400 (data 0, break bit 10 set). It takes precedence over `push_valid` in the same cycle.
- R11: When `fifo_en` differs from the registered mode, that cycle flushes the store. The count and both pointers go to 0, and the new mode is taken. `can_accept` is 0 in that cycle, and a read in that cycle pops nothing.
- R12: A push and a pop accepted in the same cycle leave the count unchanged. The new entry is stored, and the oldest entry is removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Offer `push_entry` for storage this cycle |
| push_entry | input | 12 | Entry: error bits 11:8, data bits 7:0 |
| break_evt | input | 1 | Push a break entry (0x400) this cycle |
| rd_strobe | input | 1 | Data-register read; pops the head entry |
| stat_wr | input | 1 | Status-register write; clears the latched status |
| fifo_en | input | 1 | FIFO-enable bit from line control |
| rd_data | output | 12 | Entry at the read pointer |
| flags | output | 8 | Flag image: bit 7 tx-empty, bit 6 rx-full, bit 4 rx-empty |
| rx_status | output | 4 | Error bits latched at the last read |
| can_accept | output | 1 | A push offered now would be stored |
| rx_irq | output | 1 | Receive interrupt level (trigger at one entry) |

## Verification
The assertions rely on `rst_n` being held low for at least one edge. They also assume that `fifo_en` only changes between edges, so the registered mode trails it by exactly one cycle. They do not assume that the source honours `can_accept`.

For that reason the stimulus deliberately offers pushes at full capacity, during flush cycles and together with breaks. It also issues reads on an empty store and status writes in the same cycle as reads. All inputs are driven away from the clock edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int ENTRY_W = 12;
    localparam int ERR_W   = 4;
    localparam logic [ENTRY_W-1:0] BRK_CODE = 12'h400;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && !flush) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_ptr];

    // R11
    flush_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rd_ptr == '0 && wr_ptr == '0));
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_en,
    input  logic push_req,
    input  logic rd_strobe,
    output logic can_accept,
    output logic push_ok,
    output logic pop_ok,
    output logic flush,
    output logic full_flag,
    output logic empty_flag,
    output logic irq
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP_FIFO = CW'(DEPTH);
    localparam logic [CW-1:0] TRIG_HI  = CW'(TRIG);
    localparam logic [CW-1:0] TRIG_LO  = CW'(TRIG - 1);

    occ_e          state, state_nxt;
    logic [CW-1:0] count, count_nxt;
    logic          mode_q;

    assign flush      = (fifo_en != mode_q);
    assign can_accept = !flush && (mode_q ? (count < CAP_FIFO) : (count == '0));
    assign push_ok    = push_req && can_accept;
    assign pop_ok     = rd_strobe && (count != '0) && !flush;

    always_comb begin
        if (flush) count_nxt = '0;
        else       count_nxt = count + CW'(push_ok) - CW'(pop_ok);
    end

    // next-state selection
    always_comb begin
        if (count_nxt == '0)
            state_nxt = OCC_EMPTY;
        else if (fifo_en ? (count_nxt == CAP_FIFO) : (count_nxt == CW'(1)))
            state_nxt = OCC_FULL;
        else
            state_nxt = OCC_PARTIAL;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= OCC_EMPTY;
            count  <= '0;
            mode_q <= 1'b0;
        end else begin
            state  <= state_nxt;
            count  <= count_nxt;
            mode_q <= fifo_en;
        end
    end

    // flag outputs from state
    always_comb begin
        unique case (state)
            OCC_EMPTY:   begin empty_flag = 1'b1; full_flag = 1'b0; end
            OCC_PARTIAL: begin empty_flag = 1'b0; full_flag = 1'b0; end
            OCC_FULL:    begin empty_flag = 1'b0; full_flag = 1'b1; end
            default:     begin empty_flag = 1'b1; full_flag = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (!flush) begin
            if (push_ok && !pop_ok && count_nxt == TRIG_HI)      irq <= 1'b1;
            else if (pop_ok && !push_ok && count_nxt == TRIG_LO) irq <= 1'b0;
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP_FIFO);
    // R3
    single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> count <= CW'(1));
    // R4
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OCC_FULL) |-> !can_accept);
    // R6
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && count == '0 && !push_req) |=> count == '0);
    // R11
    flush_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && state == OCC_EMPTY));
    // R12
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(count));
endmodule

// File: rtl/rxq_stat.sv
module rxq_stat #(
    parameter int EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_strobe,
    input  logic          stat_wr,
    input  logic [EW-1:0] head_err,
    output logic [EW-1:0] status
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         status <= '0;
        else if (stat_wr)   status <= '0;
        else if (rd_strobe) status <= head_err;
    end

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> status == '0);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_valid,
    input  logic [ENTRY_W-1:0] push_entry,
    input  logic               break_evt,
    input  logic               rd_strobe,
    input  logic               stat_wr,
    input  logic               fifo_en,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [7:0]         flags,
    output logic [ERR_W-1:0]   rx_status,
    output logic               can_accept,
    output logic               rx_irq
);
    logic               push_ok, pop_ok, flush, full_flag, empty_flag;
    logic [ENTRY_W-1:0] in_entry;

    assign in_entry = break_evt ? BRK_CODE : push_entry;

    rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .push_req   (push_valid | break_evt),
        .rd_strobe  (rd_strobe),
        .can_accept (can_accept),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok),
        .flush      (flush),
        .full_flag  (full_flag),
        .empty_flag (empty_flag),
        .irq        (rx_irq)
    );

    rxq_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (push_ok),
        .wr_data (in_entry),
        .rd_en   (pop_ok),
        .rd_data (rd_data)
    );

    rxq_stat #(.EW(ERR_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .stat_wr   (stat_wr),
        .head_err  (rd_data[ENTRY_W-1:ENTRY_W-ERR_W]),
        .status    (rx_status)
    );

    assign flags = {1'b1, full_flag, 1'b0, empty_flag, 4'b0000};

    // R7
    empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags[4] && flags[6]));
    // R10
    break_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (break_evt && push_ok) |-> in_entry == BRK_CODE);
endmodule

// File: tb/uart_rx_buffer_bench.sv
module uart_rx_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0, break_evt = 1'b0, rd_strobe = 1'b0;
    logic        stat_wr = 1'b0, fifo_en = 1'b0;
    logic [11:0] push_entry = '0;
    logic [11:0] rd_data;
    logic [7:0]  flags;
    logic [3:0]  rx_status;
    logic        can_accept, rx_irq;

    int n_chk = 0, n_bad = 0;

    logic [11:0] m_mem [16];
    int          m_rp = 0, m_wp = 0, m_cnt = 0;
    bit          m_mode = 0, m_irq = 0;
    logic [3:0]  m_st = '0;

    always #5 clk = ~clk;

    uart_rx_buffer u_uart_rx_buffer (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_entry(push_entry),
        .break_evt(break_evt), .rd_strobe(rd_strobe), .stat_wr(stat_wr),
        .fifo_en(fifo_en), .rd_data(rd_data), .flags(flags), .rx_status(rx_status),
        .can_accept(can_accept), .rx_irq(rx_irq)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_flags();
        bit full;
        full = m_mode ? (m_cnt == 16) : (m_cnt == 1);
        return 32'h80 | (m_cnt == 0 ? 32'h10 : 0) | (full ? 32'h40 : 0);
    endfunction

    task automatic check_regs(input string tag);
        cmp(tag, "flags", int'(flags), exp_flags());
        cmp(tag, "rx_status", int'(rx_status), int'(m_st));
        cmp(tag, "rx_irq", int'(rx_irq), int'(m_irq));
        cmp(tag, "rd_data", int'(rd_data), int'(m_mem[m_rp]));
    endtask

    // one cycle: drive after the falling edge, check combinational, model the edge, check registered
    task automatic cyc(input bit p, input logic [11:0] e, input bit b, input bit r,
                       input bit s, input bit f, input string tag);
        bit flush, acc, pushed, popped;
        logic [11:0] val, head;
        push_valid = p; push_entry = e; break_evt = b; rd_strobe = r; stat_wr = s; fifo_en = f;
        #1;
        flush = (f != m_mode);
        acc = !flush && (m_mode ? (m_cnt < 16) : (m_cnt == 0));
        cmp(tag, "can_accept", int'(can_accept), int'(acc));
        cmp(tag, "rd_data", int'(rd_data), int'(m_mem[m_rp]));
        head = m_mem[m_rp];
        val = b ? 12'h400 : e;
        pushed = (p || b) && acc;
        popped = r && m_cnt != 0 && !flush;
        @(posedge clk);
        if (s) m_st = '0;
        else if (r) m_st = head[11:8];
        if (flush) begin
            m_cnt = 0; m_rp = 0; m_wp = 0; m_mode = f;
        end else begin
            if (pushed) begin m_mem[m_wp] = val; m_wp = (m_wp + 1) % 16; m_cnt++; end
            if (popped) begin m_rp = (m_rp + 1) % 16; m_cnt--; end
            if (pushed && !popped && m_cnt == 1) m_irq = 1;
            else if (popped && !pushed && m_cnt == 0) m_irq = 0;
        end
        @(negedge clk);
        push_valid = 0; break_evt = 0; rd_strobe = 0; stat_wr = 0;
        check_regs(tag);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cmp("R1", "flags", int'(flags), 32'h90);
        cmp("R1", "can_accept", int'(can_accept), 1);
        check_regs("R1");

        // R6 read while empty
        cyc(0, 0, 0, 1, 0, 0, "R6");
        // R3 single mode holds one, R4 second push dropped
        cyc(1, 12'h3A5, 0, 0, 0, 0, "R3");
        cyc(1, 12'h03C, 0, 0, 0, 0, "R4");
        cyc(0, 0, 0, 1, 0, 0, "R8");
        cyc(0, 0, 0, 1, 0, 0, "R6");
        // R8 status write clears, clear wins over read
        cyc(0, 0, 0, 0, 1, 0, "R8");
        cyc(1, 12'h955, 0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 1, 1, 0, "R8");
        // R11 flush with an entry held, push in toggle cycle dropped; R9 irq kept
        cyc(1, 12'h011, 0, 0, 0, 0, "R9");
        cyc(1, 12'h022, 0, 1, 0, 1, "R11");
        cyc(0, 0, 0, 1, 0, 1, "R6");
        cyc(0, 0, 0, 0, 1, 1, "R8");
        // R2 fill 16 in FIFO mode, R7 flags along the way
        for (int i = 0; i < 16; i++)
            cyc(1, 12'((i << 8) | (i * 7 + 1)), 0, 0, 0, 1, "R2");
        cyc(1, 12'h0FF, 0, 0, 0, 1, "R4");
        cyc(0, 0, 1, 0, 0, 1, "R4");
        // R12 push and pop at full is blocked; below full both happen
        cyc(1, 12'h0EE, 0, 1, 0, 1, "R12");
        cyc(1, 12'h0DD, 0, 1, 0, 1, "R12");
        cyc(1, 12'h1CC, 0, 1, 0, 1, "R12");
        // R5 drain in order across wrap
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 0, 1, "R5");
        cyc(0, 0, 0, 1, 0, 1, "R7");
        // R10 break entry, and break over push
        cyc(0, 0, 1, 0, 0, 1, "R10");
        cyc(1, 12'h0AB, 1, 0, 0, 1, "R10");
        cyc(0, 0, 0, 1, 0, 1, "R10");
        cyc(0, 0, 0, 1, 0, 1, "R10");
        // R9 irq set on first push, cleared on last pop; R5 wrap again
        for (int i = 0; i < 20; i++) begin
            cyc(1, 12'(i * 13), 0, 0, 0, 1, "R9");
            cyc(0, 0, 0, 1, 0, 1, "R5");
        end
        // back to single mode: R11 flush then R3
        cyc(1, 12'h077, 0, 0, 0, 1, "R9");
        cyc(0, 0, 0, 0, 0, 0, "R11");
        cyc(1, 12'h866, 0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 1, 0, 0, "R8");
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule